// File: doc/BRIEF.md
# Keystream Session Sequencer

This block runs one frame session on an external keystream generator built from three majority-clocked shift registers. The generator is outside the block. The sequencer reaches it through a 3-bit serial control port and reads back its 1-bit keystream output.

After a start strobe, the sequencer does the following, with no gaps:

1. It pulses the generator's synchronous reset.
2. It serially loads a 64-bit session key and then a 22-bit frame number, with every register forced to shift.
3. It lets the generator mix freely for 100 cycles and throws that output away.
4. It collects 228 keystream bits into two 114-bit words, one for each link direction.

A single-cycle done pulse marks the end of the session. The two words then stay valid until the next session starts.

The sequencer holds the key and the frame number internally from the moment it accepts the start, so the inputs may change freely during a session. Control goes to a datapath through a small set of strobes. The datapath holds the serialising shift registers and the accumulator that collects the keystream.

Top module: `keystream_session_seq`

## Requirements
- R1: The control port `genCtrl` uses bit 0 as the serial load bit, bit 1 as force-shift-all and bit 2 as the generator's synchronous reset (active high). Whenever the sequencer is idle, it drives `genCtrl` to 3'b000.
- R2: A start sampled high while idle makes the cycle after that edge drive `genCtrl` = 3'b100 for exactly one cycle, with `busy` high.
- R3: The next 64 cycles drive `genCtrl` = {1'b0, 1'b1, key[i]}, where i = 0 in the first of these cycles and i rises by one in each cycle up to 63.
- R4: The next 22 cycles drive `genCtrl` = {1'b0, 1'b1, frame[j]}, where j runs from 0 to 21 in the same way.
- R5: The next 100 cycles drive `genCtrl` = 3'b000, and the generator output in these cycles is not captured.
- R6: The next 228 cycles also drive 3'b000. Each generator bit is sampled one cycle after the advance that produced it, so the bits are the outputs after the 101st through the 328th free-running advance. Exactly 228 bits are taken, with no idle cycles between the two words.
- R7: Each captured bit shifts the accumulator left by one place and enters at the LSB. The first captured bit ends up as bit 113 of `burstA`, and the 115th captured bit ends up as bit 113 of `burstB`.
- R8: Key 64'hEFCDAB8967452312 with frame 22'h000134 yields `burstA` = 114'h14D3AA960BFA0546ADB861569CA30 and `burstB` = 114'h093F4D68D757ED949B4CBE41B7C6B.
- R9: `busy` is high for the 416 cycles after the accepted start. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R10: A start that arrives while `busy` is high is ignored. Changes on `sessionKey` or `frameNum` after the start has been accepted do not affect the session.
- R11: From the done cycle until the next accepted start, `burstA` and `burstB` hold their values.
- R12: An asynchronous active-low `rst_n` returns the block to idle at once: `busy` = 0, `done` = 0, `genCtrl` = 3'b000 and both words at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session start strobe, acted on only while idle |
| sessionKey | input | 64 | Session key, sampled when the start is accepted |
| frameNum | input | 22 | Frame number, sampled when the start is accepted |
| genOut | input | 1 | Keystream bit from the external generator |
| genCtrl | output | 3 | Generator control: {reset, force-shift, serial data} |
| busy | output | 1 | A session is in progress |
| done | output | 1 | One-cycle pulse at the end of a session |
| burstA | output | 114 | First-direction keystream word, first bit at the MSB |
| burstB | output | 114 | Second-direction keystream word, first bit at the MSB |

## Verification
The alignment of the captured bits is the hardest part to pin down from the ports. A capture that is one cycle early or late still yields plausible-looking words. The bench therefore runs a generator model from the control port it observes, and it compares every session against a reference computed separately in the bench, including the fixed known-answer session. The other hard cases are a start strobe in the middle of a session, key and frame inputs that change mid-session, and an asynchronous reset during the mixing phase. The bench drives these at chosen cycle offsets inside the 416-cycle window and then checks the control trace and the output words.

// File: rtl/keystream_seq_pkg.sv
package keystream_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_KEY,
    PH_FRAME,
    PH_MIX,
    PH_BURST_A,
    PH_BURST_B,
    PH_TAIL
  } phase_t;

  typedef struct packed {
    logic beginSession;
    logic shiftKey;
    logic shiftFrame;
    logic captureBit;
  } seq_strobe_t;

endpackage

// File: rtl/keystream_seq_ctrl.sv
module keystream_seq_ctrl
  import keystream_seq_pkg::*;
#(
  parameter int KEY_W      = 64,
  parameter int FRAME_W    = 22,
  parameter int MIX_CYCLES = 100,
  parameter int BURST_W    = 114
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output seq_strobe_t strobe,
  output logic        genReset,
  output logic        forceClk,
  output logic        busy,
  output logic        done
);

  localparam int MAX_A   = (KEY_W > FRAME_W) ? KEY_W : FRAME_W;
  localparam int MAX_B   = (MIX_CYCLES > BURST_W) ? MIX_CYCLES : BURST_W;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0] KEY_LAST   = CNT_W'(KEY_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] MIX_LAST   = CNT_W'(MIX_CYCLES - 1);
  localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_W - 1);
  localparam int CAP_W = $clog2(2 * BURST_W + 1);

  phase_t           phase;
  logic [CNT_W-1:0] phaseCnt;
  logic             capturePending;
  logic             lastOfPhase;

  assign lastOfPhase = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase          <= PH_IDLE;
      phaseCnt       <= '0;
      capturePending <= 1'b0;
      done           <= 1'b0;
    end else begin
      done           <= (phase == PH_TAIL);
      capturePending <= (phase == PH_BURST_A) || (phase == PH_BURST_B);
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_RESET;
            phaseCnt <= '0;
          end
        end
        PH_RESET: begin
          phase    <= PH_KEY;
          phaseCnt <= KEY_LAST;
        end
        PH_KEY: begin
          if (lastOfPhase) begin
            phase    <= PH_FRAME;
            phaseCnt <= FRAME_LAST;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        PH_FRAME: begin
          if (lastOfPhase) begin
            phase    <= PH_MIX;
            phaseCnt <= MIX_LAST;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        PH_MIX: begin
          if (lastOfPhase) begin
            phase    <= PH_BURST_A;
            phaseCnt <= BURST_LAST;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        PH_BURST_A: begin
          if (lastOfPhase) begin
            phase    <= PH_BURST_B;
            phaseCnt <= BURST_LAST;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        PH_BURST_B: begin
          if (lastOfPhase) begin
            phase    <= PH_TAIL;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: begin
          phase    <= PH_IDLE;
          phaseCnt <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.beginSession = (phase == PH_IDLE) && start;
    strobe.shiftKey     = (phase == PH_KEY);
    strobe.shiftFrame   = (phase == PH_FRAME);
    strobe.captureBit   = capturePending;
  end

  assign genReset = (phase == PH_RESET);
  assign forceClk = strobe.shiftKey || strobe.shiftFrame;
  assign busy     = (phase != PH_IDLE);

  // Capture tally, used only by the checks below.
  logic [CAP_W-1:0] capCount;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   capCount <= '0;
    else if (strobe.beginSession) capCount <= '0;
    else if (strobe.captureBit)   capCount <= capCount + 1'b1;
  end

  assert_start_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (genReset && busy));

  assert_reset_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    genReset |=> (!genReset && forceClk));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    genReset |-> !$past(busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_capture_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (capCount == CAP_W'(2 * BURST_W)));

endmodule

// File: rtl/keystream_seq_datapath.sv
module keystream_seq_datapath
  import keystream_seq_pkg::*;
#(
  parameter int KEY_W   = 64,
  parameter int FRAME_W = 22,
  parameter int BURST_W = 114
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_strobe_t        strobe,
  input  logic [KEY_W-1:0]   sessionKey,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               genOut,
  output logic               serialBit,
  output logic [BURST_W-1:0] burstA,
  output logic [BURST_W-1:0] burstB
);

  localparam int ACC_W = 2 * BURST_W;

  logic [KEY_W-1:0]   keyReg;
  logic [FRAME_W-1:0] frameReg;
  logic [ACC_W-1:0]   acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keyReg   <= '0;
      frameReg <= '0;
    end else if (strobe.beginSession) begin
      keyReg   <= sessionKey;
      frameReg <= frameNum;
    end else begin
      if (strobe.shiftKey)   keyReg   <= keyReg >> 1;
      if (strobe.shiftFrame) frameReg <= frameReg >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   acc <= '0;
    else if (strobe.beginSession) acc <= '0;
    else if (strobe.captureBit)   acc <= {acc[ACC_W-2:0], genOut};
  end

  always_comb begin
    if (strobe.shiftKey)        serialBit = keyReg[0];
    else if (strobe.shiftFrame) serialBit = frameReg[0];
    else                        serialBit = 1'b0;
  end

  assign burstA = acc[ACC_W-1:BURST_W];
  assign burstB = acc[BURST_W-1:0];

  assert_serial_key_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.shiftKey && $past(strobe.shiftKey)) |-> (serialBit == $past(keyReg[1])));

endmodule

// File: rtl/keystream_session_seq.sv
module keystream_session_seq
  import keystream_seq_pkg::*;
#(
  parameter int KEY_W      = 64,
  parameter int FRAME_W    = 22,
  parameter int MIX_CYCLES = 100,
  parameter int BURST_W    = 114
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [KEY_W-1:0]   sessionKey,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               genOut,
  output logic [2:0]         genCtrl,
  output logic               busy,
  output logic               done,
  output logic [BURST_W-1:0] burstA,
  output logic [BURST_W-1:0] burstB
);

  seq_strobe_t strobe;
  logic        genReset;
  logic        forceClk;
  logic        serialBit;

  keystream_seq_ctrl #(
    .KEY_W(KEY_W), .FRAME_W(FRAME_W), .MIX_CYCLES(MIX_CYCLES), .BURST_W(BURST_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe),
    .genReset(genReset), .forceClk(forceClk), .busy(busy), .done(done)
  );

  keystream_seq_datapath #(
    .KEY_W(KEY_W), .FRAME_W(FRAME_W), .BURST_W(BURST_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sessionKey(sessionKey),
    .frameNum(frameNum), .genOut(genOut), .serialBit(serialBit),
    .burstA(burstA), .burstB(burstB)
  );

  assign genCtrl = {genReset, forceClk, serialBit};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (genCtrl == 3'b000));

  assert_words_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(burstA) && $stable(burstB)));

endmodule

// File: tb/keystream_session_seq_bench.sv
module keystream_session_seq_bench;

  localparam int SESSION = 416;

  // Generator state packed as {regA[18:0], regB[21:0], regC[22:0]}
  function automatic logic [63:0] advance(input logic [63:0] s, input logic force1, input logic d);
    logic [18:0] a; logic [21:0] b; logic [22:0] c;
    logic fa, fb, fc, maj;
    a = s[63:45]; b = s[44:23]; c = s[22:0];
    maj = (int'(a[8]) + int'(b[10]) + int'(c[10])) >= 2;
    fa = d ^ a[13] ^ a[16] ^ a[17] ^ a[18];
    fb = d ^ b[20] ^ b[21];
    fc = d ^ c[7] ^ c[20] ^ c[21] ^ c[22];
    if (force1 || (a[8] == maj))  a = {a[17:0], fa};
    if (force1 || (b[10] == maj)) b = {b[20:0], fb};
    if (force1 || (c[10] == maj)) c = {c[21:0], fc};
    return {a, b, c};
  endfunction

  function automatic logic outOf(input logic [63:0] s);
    return s[63] ^ s[44] ^ s[22];
  endfunction

  function automatic logic [227:0] refBursts(input logic [63:0] k, input logic [21:0] f);
    logic [63:0] s; logic [227:0] r;
    s = '0; r = '0;
    for (int i = 0; i < 64; i++) s = advance(s, 1'b1, k[i]);
    for (int i = 0; i < 22; i++) s = advance(s, 1'b1, f[i]);
    for (int i = 0; i < 100; i++) s = advance(s, 1'b0, 1'b0);
    for (int i = 0; i < 228; i++) begin
      s = advance(s, 1'b0, 1'b0);
      r = {r[226:0], outOf(s)};
    end
    return r;
  endfunction

  localparam logic [115:0] KNOWN_A = 116'h14D3AA960BFA0546ADB861569CA30;
  localparam logic [115:0] KNOWN_B = 116'h093F4D68D757ED949B4CBE41B7C6B;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  sessionKey = '0;
  logic [21:0]  frameNum = '0;
  logic         genOut;
  logic [2:0]   genCtrl;
  logic         busy, done;
  logic [113:0] burstA, burstB;

  logic [63:0] genState = '0;
  always @(posedge clk) genState <= genCtrl[2] ? 64'd0 : advance(genState, genCtrl[1], genCtrl[0]);
  assign genOut = outOf(genState);

  keystream_session_seq u_keystream_session_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sessionKey(sessionKey),
    .frameNum(frameNum), .genOut(genOut), .genCtrl(genCtrl), .busy(busy),
    .done(done), .burstA(burstA), .burstB(burstB)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [227:0] act, input logic [227:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runSession(input logic [63:0] k, input logic [21:0] f,
                            input bit inject, input bit known);
    logic [227:0] exp;
    int bad[5];
    logic [2:0] firstAct[5], firstExp[5];
    int busyBad;
    logic [2:0] want;
    int reg_i;
    exp = refBursts(k, f);
    for (int i = 0; i < 5; i++) begin bad[i] = 0; firstAct[i] = '0; firstExp[i] = '0; end
    busyBad = 0;
    sessionKey = k; frameNum = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= SESSION; c++) begin
      if (c == 1)       begin reg_i = 0; want = 3'b100; end
      else if (c <= 65) begin reg_i = 1; want = {2'b01, k[c-2]}; end
      else if (c <= 87) begin reg_i = 2; want = {2'b01, f[c-66]}; end
      else if (c <= 187) begin reg_i = 3; want = 3'b000; end
      else              begin reg_i = 4; want = 3'b000; end
      if (genCtrl !== want) begin
        if (bad[reg_i] == 0) begin firstAct[reg_i] = genCtrl; firstExp[reg_i] = want; end
        bad[reg_i]++;
      end
      if (busy !== 1'b1 || done !== 1'b0) busyBad++;
      if (inject && c == 200) begin start = 1'b1; sessionKey = ~k; frameNum = ~f; end
      if (inject && c == 201) start = 1'b0;
      @(negedge clk);
    end
    check(bad[0] == 0, "R2", "reset cycle control", 228'(firstAct[0]), 228'(firstExp[0]));
    check(bad[1] == 0, "R3", "key load control", 228'(firstAct[1]), 228'(firstExp[1]));
    check(bad[2] == 0, "R4", "frame load control", 228'(firstAct[2]), 228'(firstExp[2]));
    check(bad[3] == 0, "R5", "mix phase control", 228'(firstAct[3]), 228'(firstExp[3]));
    check(bad[4] == 0, "R6", "capture phase control", 228'(firstAct[4]), 228'(firstExp[4]));
    check(busyBad == 0, "R9", "busy high during session", 228'(busyBad), 228'(0));
    check(done === 1'b1 && busy === 1'b0, "R9", "done pulse at end",
          228'({done, busy}), 228'(2'b10));
    check(genCtrl === 3'b000, "R1", "idle control after session", 228'(genCtrl), 228'(0));
    check({burstA, burstB} === exp, inject ? "R10" : "R7", "burst words",
          {burstA, burstB}, exp);
    if (known) begin
      check(exp === {KNOWN_A[113:0], KNOWN_B[113:0]}, "R8", "bench reference vs known",
            exp, {KNOWN_A[113:0], KNOWN_B[113:0]});
      check(burstA === KNOWN_A[113:0], "R8", "first burst", 228'(burstA), 228'(KNOWN_A[113:0]));
      check(burstB === KNOWN_B[113:0], "R8", "second burst", 228'(burstB), 228'(KNOWN_B[113:0]));
    end
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9", "done single cycle",
          228'({done, busy}), 228'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [227:0] held;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R12", "reset state flags",
          228'({busy, done}), 228'(0));
    check(genCtrl === 3'b000, "R1", "reset state control", 228'(genCtrl), 228'(0));
    check({burstA, burstB} === 228'(0), "R12", "reset state words", {burstA, burstB}, 228'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Known-answer session
    runSession(64'hEFCDAB8967452312, 22'h000134, 1'b0, 1'b1);

    // R11: words hold while idle and inputs wander
    held = {burstA, burstB};
    for (int i = 0; i < 30; i++) begin
      sessionKey = {32'(i * 7919), 32'(i * 104729)};
      frameNum = 22'(i * 31);
      @(negedge clk);
    end
    check({burstA, burstB} === held, "R11", "words held while idle", {burstA, burstB}, held);
    check(genCtrl === 3'b000 && busy === 1'b0, "R1", "quiet while idle",
          228'({genCtrl, busy}), 228'(0));

    // Sweep of key and frame patterns
    runSession(64'h0, 22'h0, 1'b0, 1'b0);
    runSession(64'hFFFF_FFFF_FFFF_FFFF, 22'h3FFFFF, 1'b0, 1'b0);
    runSession(64'h8000_0000_0000_0000, 22'h000001, 1'b0, 1'b0);
    runSession(64'h0000_0000_0000_0001, 22'h200000, 1'b0, 1'b0);
    runSession(64'hA5A5_5A5A_F00F_0FF0, 22'h15555A, 1'b0, 1'b0);
    runSession(64'h0123_4567_89AB_CDEF, 22'h2AAAAA, 1'b0, 1'b0);

    // R10: stray start and changing inputs mid-session
    runSession(64'h1357_9BDF_2468_ACE0, 22'h0ABCDE, 1'b1, 1'b0);

    // R12: asynchronous reset during the mix phase
    sessionKey = 64'hDEAD_BEEF_0BAD_F00D; frameNum = 22'h12345; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (150) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check(busy === 1'b0 && done === 1'b0, "R12", "async reset flags", 228'({busy, done}), 228'(0));
    check(genCtrl === 3'b000, "R12", "async reset control", 228'(genCtrl), 228'(0));
    check({burstA, burstB} === 228'(0), "R12", "async reset words", {burstA, burstB}, 228'(0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && genCtrl === 3'b000, "R12", "idle after reset release",
          228'({busy, genCtrl}), 228'(0));
    runSession(64'hDEAD_BEEF_0BAD_F00D, 22'h12345, 1'b0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule